// File: doc/BRIEF.md
# Comb Filter Source Select Controller

This controller picks the luma/chroma path that feeds a colour decoder. There are three candidates: the direct composite input, the separate Y/C input, and the Y/C return from an external comb filter. The choice depends on the source mode register, the identified colour standard, the crystal the decoder is using, and two burst-presence flags. The burst flags come from detectors outside the block.

The block drives a two-bit standard code that tells the external comb filter which standard to process. It gates the subcarrier reference sent to that filter and raises a status bit while the comb return is in use. It also produces the chroma trap enable, which follows the colour identification and the fixed-subcarrier setting. The path select, the standard code and the status bit are registered and change only on a line-rate strobe, so a switch never happens in the middle of a line.

Top module: `comb_src_sel`

## Requirements
- R1: After reset, `path_sel` is 00 (composite), `std_sel` is 00 and `comb_active` is 0.
- R2: `path_sel`, `std_sel` and `comb_active` change only on a clock edge where `line_strobe` is 1, and hold their value otherwise.
- R3: A combable pairing is `std_id`=01 (PAL) with `xtal_sel` 00, 10 or 11, or `std_id`=10 (NTSC) with `xtal_sel`=01. On a strobe, `std_sel` takes 00 (PAL-B/G) for PAL with crystal 00, 01 (PAL-M) for PAL with crystal 10, 10 (PAL-N) for PAL with crystal 11, and 11 (NTSC-M) for NTSC with crystal 01. Any other pairing gives 00.
- R4: The comb return (`path_sel`=10) is taken only when `comb_en` is 1 and the pairing is combable.
- R5: `std_id`=11 (SECAM) and `std_id`=00 (no colour, black-and-white) never lead to the comb return.
- R6: `src_mode`=00 (composite) selects the comb return when R4 allows it, and composite otherwise.
- R7: `src_mode`=01 (Y/C) always selects Y/C (`path_sel`=01), even when the pairing is combable.
- R8: `src_mode`=10 (auto Y/C) selects Y/C when `burst_chroma` is 1 and composite otherwise. It never selects the comb return.
- R9: `src_mode`=11 (auto comb) selects Y/C when `burst_chroma` is 1. Otherwise it selects the comb return when `burst_cvbs` is 1 and R4 allows it, and composite in every other case.
- R10: `comb_active` is 1 exactly when `path_sel` is 10.
- R11: `sc_ref_out` is 0 whenever `comb_en` is 0, and equals `sc_ref` when `comb_en` is 1.
- R12: `trap_en` is 1 when `fixed_sc` is 1 or when `std_id` is not 00. It is 0 when `fixed_sc` is 0 and no colour is identified.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| line_strobe | input | 1 | One-cycle strobe at the line boundary; selections update only here |
| comb_en | input | 1 | Global comb enable |
| src_mode | input | 2 | 00 composite, 01 Y/C, 10 auto Y/C, 11 auto comb |
| std_id | input | 2 | Identified standard: 00 none, 01 PAL, 10 NTSC, 11 SECAM |
| xtal_sel | input | 2 | Crystal in use: 00 4.43 MHz, 01 NTSC 3.58, 10 PAL-M, 11 PAL-N |
| burst_cvbs | input | 1 | Burst seen on the composite input |
| burst_chroma | input | 1 | Burst seen on the chroma input |
| fixed_sc | input | 1 | Decoder forced to one fixed subcarrier |
| sc_ref | input | 1 | Subcarrier reference in |
| path_sel | output | 2 | 00 composite, 01 Y/C, 10 comb return |
| std_sel | output | 2 | Standard code sent to the comb filter |
| comb_active | output | 1 | Comb return in use |
| sc_ref_out | output | 1 | Gated subcarrier reference to the comb filter |
| trap_en | output | 1 | Chroma trap enable |

## Verification
The assertions take for granted that the control inputs are stable on the clock edge where `line_strobe` is sampled. They also assume the strobe is a single-cycle pulse, so every selection is checked one edge after the strobe. The stimulus sets all controls on the falling edge, raises `line_strobe` for exactly one cycle, and samples the outputs on the following falling edge. For the mid-line hold check, the bench changes the controls with the strobe held low and confirms that the registered outputs do not move.

// File: rtl/comb_src_sel.sv
module comb_src_sel (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       line_strobe,
  input  logic       comb_en,
  input  logic [1:0] src_mode,
  input  logic [1:0] std_id,
  input  logic [1:0] xtal_sel,
  input  logic       burst_cvbs,
  input  logic       burst_chroma,
  input  logic       fixed_sc,
  input  logic       sc_ref,
  output logic [1:0] path_sel,
  output logic [1:0] std_sel,
  output logic       comb_active,
  output logic       sc_ref_out,
  output logic       trap_en
);
  localparam logic [1:0] P_CVBS = 2'b00, P_YC = 2'b01, P_COMB = 2'b10;
  localparam logic [1:0] M_CVBS = 2'b00, M_YC = 2'b01, M_AUTO_YC = 2'b10, M_AUTO_CMB = 2'b11;

  logic       pair_ok;
  logic [1:0] pair_code;
  logic [1:0] next_path;
  logic       comb_ok;

  always_comb begin
    pair_ok   = 1'b0;
    pair_code = 2'b00;
    if (std_id == 2'b01) begin
      case (xtal_sel)
        2'b00:   begin pair_ok = 1'b1; pair_code = 2'b00; end
        2'b10:   begin pair_ok = 1'b1; pair_code = 2'b01; end
        2'b11:   begin pair_ok = 1'b1; pair_code = 2'b10; end
        default: begin pair_ok = 1'b0; pair_code = 2'b00; end
      endcase
    end else if (std_id == 2'b10 && xtal_sel == 2'b01) begin
      pair_ok   = 1'b1;
      pair_code = 2'b11;
    end
  end

  assign comb_ok = comb_en & pair_ok;

  always_comb begin
    case (src_mode)
      M_CVBS:     next_path = comb_ok ? P_COMB : P_CVBS;
      M_YC:       next_path = P_YC;
      M_AUTO_YC:  next_path = burst_chroma ? P_YC : P_CVBS;
      M_AUTO_CMB: next_path = burst_chroma ? P_YC :
                              (burst_cvbs && comb_ok) ? P_COMB : P_CVBS;
      default:    next_path = P_CVBS;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      path_sel    <= P_CVBS;
      std_sel     <= 2'b00;
      comb_active <= 1'b0;
    end else if (line_strobe) begin
      path_sel    <= next_path;
      std_sel     <= pair_code;
      comb_active <= (next_path == P_COMB);
    end
  end

  assign sc_ref_out = comb_en & sc_ref;
  assign trap_en    = fixed_sc | (std_id != 2'b00);
endmodule

module comb_src_sel_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       line_strobe,
  input logic       comb_en,
  input logic [1:0] src_mode,
  input logic [1:0] std_id,
  input logic       fixed_sc,
  input logic [1:0] path_sel,
  input logic [1:0] std_sel,
  input logic       comb_active,
  input logic       sc_ref_out,
  input logic       trap_en
);
  // R2
  hold_midline_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !line_strobe |=> ($stable(path_sel) && $stable(std_sel) && $stable(comb_active)));
  // R4
  comb_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (line_strobe && !comb_en) |=> (path_sel != 2'b10));
  // R5
  no_comb_secam_bw_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (line_strobe && (std_id == 2'b11 || std_id == 2'b00)) |=> !comb_active);
  // R7
  yc_forced_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (line_strobe && src_mode == 2'b01) |=> (path_sel == 2'b01));
  // R10
  status_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    comb_active == (path_sel == 2'b10));
  // R11
  ref_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !comb_en |-> !sc_ref_out);
  // R12
  trap_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fixed_sc |-> trap_en);
endmodule

bind comb_src_sel comb_src_sel_chk u_chk (
  .clk(clk), .rst_n(rst_n), .line_strobe(line_strobe), .comb_en(comb_en),
  .src_mode(src_mode), .std_id(std_id), .fixed_sc(fixed_sc),
  .path_sel(path_sel), .std_sel(std_sel), .comb_active(comb_active),
  .sc_ref_out(sc_ref_out), .trap_en(trap_en)
);

// File: tb/comb_src_sel_bench.sv
module comb_src_sel_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic line_strobe = 1'b0, comb_en = 1'b0, burst_cvbs = 1'b0, burst_chroma = 1'b0;
  logic fixed_sc = 1'b0, sc_ref = 1'b0;
  logic [1:0] src_mode = 2'b00, std_id = 2'b00, xtal_sel = 2'b00;
  logic [1:0] path_sel, std_sel;
  logic comb_active, sc_ref_out, trap_en;
  int errors = 0, checks = 0;

  always #10 clk = ~clk;

  comb_src_sel u_comb_src_sel (
    .clk(clk), .rst_n(rst_n), .line_strobe(line_strobe), .comb_en(comb_en),
    .src_mode(src_mode), .std_id(std_id), .xtal_sel(xtal_sel),
    .burst_cvbs(burst_cvbs), .burst_chroma(burst_chroma), .fixed_sc(fixed_sc),
    .sc_ref(sc_ref), .path_sel(path_sel), .std_sel(std_sel),
    .comb_active(comb_active), .sc_ref_out(sc_ref_out), .trap_en(trap_en)
  );

  // {en, mode[2], std[2], xtal[2], bcvbs, bchroma, exp_path[2], exp_std[2]}
  localparam int NV = 16;
  localparam logic [12:0] VEC [NV] = '{
    {1'b1, 2'b00, 2'b01, 2'b00, 1'b0, 1'b0, 2'b10, 2'b00}, // R3 R6 PAL B/G comb
    {1'b1, 2'b00, 2'b01, 2'b10, 1'b0, 1'b0, 2'b10, 2'b01}, // R3 PAL-M
    {1'b1, 2'b00, 2'b01, 2'b11, 1'b0, 1'b0, 2'b10, 2'b10}, // R3 PAL-N
    {1'b1, 2'b00, 2'b10, 2'b01, 1'b0, 1'b0, 2'b10, 2'b11}, // R3 NTSC-M
    {1'b0, 2'b00, 2'b01, 2'b00, 1'b0, 1'b0, 2'b00, 2'b00}, // R4 disabled
    {1'b0, 2'b00, 2'b10, 2'b01, 1'b0, 1'b0, 2'b00, 2'b11}, // R4 disabled NTSC
    {1'b1, 2'b00, 2'b11, 2'b00, 1'b0, 1'b0, 2'b00, 2'b00}, // R5 SECAM
    {1'b1, 2'b00, 2'b00, 2'b00, 1'b0, 1'b0, 2'b00, 2'b00}, // R5 no colour
    {1'b1, 2'b00, 2'b10, 2'b00, 1'b0, 1'b0, 2'b00, 2'b00}, // R4 mismatch
    {1'b1, 2'b01, 2'b01, 2'b00, 1'b1, 1'b0, 2'b01, 2'b00}, // R7 Y/C source
    {1'b1, 2'b10, 2'b01, 2'b00, 1'b0, 1'b1, 2'b01, 2'b00}, // R8 chroma burst
    {1'b1, 2'b10, 2'b01, 2'b00, 1'b1, 1'b0, 2'b00, 2'b00}, // R8 composite burst
    {1'b1, 2'b11, 2'b01, 2'b00, 1'b1, 1'b1, 2'b01, 2'b00}, // R9 chroma wins
    {1'b1, 2'b11, 2'b01, 2'b00, 1'b1, 1'b0, 2'b10, 2'b00}, // R9 comb
    {1'b1, 2'b11, 2'b11, 2'b00, 1'b1, 1'b0, 2'b00, 2'b00}, // R9 R5 SECAM
    {1'b1, 2'b11, 2'b01, 2'b00, 1'b0, 1'b0, 2'b00, 2'b00}  // R9 no burst
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic strobe();
    @(negedge clk) line_strobe = 1'b1;
    @(negedge clk) line_strobe = 1'b0;
  endtask

  initial begin
    #2_000_000;
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 path", path_sel, 0);
    check("R1 std", std_sel, 0);
    check("R1 status", comb_active, 0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      {comb_en, src_mode, std_id, xtal_sel, burst_cvbs, burst_chroma} = VEC[i][12:4];
      strobe();
      check("R6/R7/R8/R9 path", path_sel, VEC[i][3:2]);
      check("R3 std_sel", std_sel, VEC[i][1:0]);
      check("R10 status", comb_active, VEC[i][3:2] == 2'b10);
    end

    // R2: inputs change mid-line, outputs hold until the strobe
    @(negedge clk);
    {comb_en, src_mode, std_id, xtal_sel} = {1'b1, 2'b00, 2'b10, 2'b01};
    repeat (3) @(negedge clk);
    check("R2 hold path", path_sel, 0);
    check("R2 hold std", std_sel, 0);
    strobe();
    check("R2 update path", path_sel, 2);
    check("R2 update std", std_sel, 3);

    // R11 reference gating
    sc_ref = 1'b1; comb_en = 1'b0; #1;
    check("R11 suppressed", sc_ref_out, 0);
    comb_en = 1'b1; #1;
    check("R11 passed", sc_ref_out, 1);
    sc_ref = 1'b0; #1;
    check("R11 follows", sc_ref_out, 0);

    // R12 trap enable
    fixed_sc = 1'b0; std_id = 2'b00; #1;
    check("R12 off", trap_en, 0);
    fixed_sc = 1'b1; #1;
    check("R12 fixed", trap_en, 1);
    fixed_sc = 1'b0; std_id = 2'b11; #1;
    check("R12 colour", trap_en, 1);

    @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule